// File: doc/BRIEF.md
# Threshold FIFO Request Generator

This block drives the active-low DMA request line for a single 16-word FIFO, on either side of a data path. On the fill side (a FIFO that a DMA engine writes into), it asks for data when the FIFO runs low and withdraws the request once it has filled up. On the drain side (a FIFO that a DMA engine reads from), it asks the engine to take data when the FIFO fills up or holds an end-of-record word. It stops asking when that word is strobed out or when the FIFO has drained. Both thresholds are 4-bit programmable values. Between them the request keeps its last state, so a burst can run without the line toggling on every word.

A threshold crossing reaches the request pin after a fixed pipeline latency, measured from the occupancy count. A FIFO clear, an overflow or underflow flag and the end-of-record signals skip that pipeline. On the drain side, a configuration bit chooses how the request drops when an end-of-record word leaves: either at once, in the strobe cycle itself, or one clock later and then held low for at least one clock. An active-high copy of the request is provided as a status bit. The FIFO storage itself sits outside this block.

Top module: `fifo_req_gen`

## Requirements
- R1: A synchronous `rst` or a `fifo_clear` sampled at a rising edge makes the request inactive (`req_n`=1) after that edge, whatever the other inputs are.
- R2: When `err_flag` is 1 at a rising edge and there is no clear, the request is inactive after that edge. This flag ranks above every threshold and end-of-record rule.
- R3: Fill side (`SIDE`=SIDE_FILL, encoding 0): the request becomes active when the occupancy is less than or equal to `thr_empty`, and inactive when the occupancy is greater than or equal to `thr_full`. When both conditions hold, the empty rule wins.
- R4: Drain side (`SIDE`=SIDE_DRAIN, encoding 1): the request becomes active when the occupancy is greater than or equal to `thr_full`, and inactive when the occupancy is less than or equal to `thr_empty`. When both conditions hold, the full rule wins.
- R5: While the occupancy lies strictly between the two thresholds, and no other rule applies, the request keeps its previous state.
- R6: A change of `level` first affects the request after the LAT-th rising edge that samples it (LAT=3 by default), and not before. Clear, error and end-of-record inputs act after a single edge.
- R7: On the drain side, `eor_present`=1 at an edge makes the request active after that edge, unless an end-of-record strobe occurs in the same cycle.
- R8: On the drain side, when `late_drop`=0, a cycle with `strobe`=1 and `strobe_eor`=1 drives `req_n` high combinationally within that same cycle, and the request stays inactive after the edge.
- R9: On the drain side, when `late_drop`=1, the pin stays as it was during the end-of-record strobe cycle. After that edge it is inactive for at least one clock, even if `eor_present` or the full threshold still holds.
- R10: `req_status` is always the active-high inverse of `req_n`.
- R11: On the fill side, `eor_present`, `strobe`, `strobe_eor` and `late_drop` have no effect on the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clear | input | 1 | FIFO clear bit; forces the request inactive |
| err_flag | input | 1 | Overflow flag (fill side) or underflow flag (drain side) |
| level | input | CNT_W (5) | FIFO occupancy, 0 to DEPTH |
| thr_empty | input | THR_W (4) | Empty threshold |
| thr_full | input | THR_W (4) | Full threshold |
| eor_present | input | 1 | An end-of-record word is held in the FIFO |
| strobe | input | 1 | A word is transferred this cycle |
| strobe_eor | input | 1 | The transferred word carries the end-of-record tag |
| late_drop | input | 1 | 0: drop in the strobe cycle; 1: drop after the next edge |
| req_n | output | 1 | Active-low DMA request |
| req_status | output | 1 | Active-high request status |

## Verification
The bench builds two copies at DEPTH=16 and LAT=3: one with the fill-side variant and one with the drain-side variant. Both copies share one set of stimulus, so a single sequence of occupancy and threshold values exercises the opposite priority orders side by side. With a 5-bit count against 4-bit thresholds, an occupancy of 16 lies above every threshold value, and crossed thresholds (empty above full) expose which rule wins. A LAT of 3 is short enough that the cycle before and the cycle of the change can both be sampled.

// File: rtl/fifo_req_pkg.sv
package fifo_req_pkg;
  typedef enum logic {
    SIDE_FILL  = 1'b0,
    SIDE_DRAIN = 1'b1
  } fifo_side_e;
endpackage

// File: rtl/fifo_req_lvl_pipe.sv
// Delay line that aligns the occupancy count with the request latency.
module fifo_req_lvl_pipe #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else     st[g] <= st[g-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/fifo_req_thr_cmp.sv
// Threshold comparison of the delayed occupancy.
module fifo_req_thr_cmp #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic [CNT_W-1:0] lvl,
  input  logic [THR_W-1:0] thr_e,
  input  logic [THR_W-1:0] thr_f,
  output logic             at_empty,
  output logic             at_full
);
  localparam int PADW = CNT_W - THR_W;

  logic [CNT_W-1:0] e_ext, f_ext;

  assign e_ext    = {{PADW{1'b0}}, thr_e};
  assign f_ext    = {{PADW{1'b0}}, thr_f};
  assign at_empty = (lvl <= e_ext);
  assign at_full  = (lvl >= f_ext);
endmodule

// File: rtl/fifo_req_core.sv
// Priority-ordered request register with a side-selected rule set.
module fifo_req_core
  import fifo_req_pkg::*;
#(
  parameter fifo_side_e SIDE = SIDE_FILL
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_clear,
  input  logic err_flag,
  input  logic at_empty,
  input  logic at_full,
  input  logic eor_present,
  input  logic eor_strobe,
  input  logic late_drop,
  output logic req_n,
  output logic req_status
);
  localparam bit DRAIN = (SIDE == SIDE_DRAIN);

  logic req_q;
  logic drop_now;

  always_ff @(posedge clk) begin
    if (rst || fifo_clear) begin
      req_q <= 1'b0;
    end else if (err_flag) begin
      req_q <= 1'b0;
    end else if (DRAIN) begin
      // End-of-record strobe wins for one edge so the line always drops.
      if (eor_strobe)                   req_q <= 1'b0;
      else if (eor_present || at_full)  req_q <= 1'b1;
      else if (at_empty)                req_q <= 1'b0;
    end else begin
      if (at_empty)      req_q <= 1'b1;
      else if (at_full)  req_q <= 1'b0;
    end
  end

  // Early mode: the pin releases inside the strobe cycle itself.
  assign drop_now   = DRAIN && eor_strobe && !late_drop;
  assign req_status = req_q && !drop_now;
  assign req_n      = !req_status;
endmodule

// File: rtl/fifo_req_gen.sv
module fifo_req_gen
  import fifo_req_pkg::*;
#(
  parameter int         DEPTH = 16,
  parameter int         LAT   = 3,
  parameter fifo_side_e SIDE  = SIDE_FILL,
  localparam int        CNT_W = $clog2(DEPTH + 1),
  localparam int        THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_clear,
  input  logic             err_flag,
  input  logic [CNT_W-1:0] level,
  input  logic [THR_W-1:0] thr_empty,
  input  logic [THR_W-1:0] thr_full,
  input  logic             eor_present,
  input  logic             strobe,
  input  logic             strobe_eor,
  input  logic             late_drop,
  output logic             req_n,
  output logic             req_status
);
  localparam int STAGES = LAT - 1;

  logic [CNT_W-1:0] lvl_d;
  logic             at_empty, at_full;
  logic             eor_strobe;

  assign eor_strobe = strobe && strobe_eor;

  fifo_req_lvl_pipe #(.W(CNT_W), .STAGES(STAGES)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .din  (level),
    .dout (lvl_d)
  );

  fifo_req_thr_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
    .lvl      (lvl_d),
    .thr_e    (thr_empty),
    .thr_f    (thr_full),
    .at_empty (at_empty),
    .at_full  (at_full)
  );

  fifo_req_core #(.SIDE(SIDE)) u_core (
    .clk         (clk),
    .rst         (rst),
    .fifo_clear  (fifo_clear),
    .err_flag    (err_flag),
    .at_empty    (at_empty),
    .at_full     (at_full),
    .eor_present (eor_present),
    .eor_strobe  (eor_strobe),
    .late_drop   (late_drop),
    .req_n       (req_n),
    .req_status  (req_status)
  );
endmodule

// File: rtl/fifo_req_gen_chk.sv
module fifo_req_gen_chk
  import fifo_req_pkg::*;
#(
  parameter int         DEPTH = 16,
  parameter int         LAT   = 3,
  parameter fifo_side_e SIDE  = SIDE_FILL,
  localparam int        CNT_W = $clog2(DEPTH + 1),
  localparam int        THR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_clear,
  input logic             err_flag,
  input logic [CNT_W-1:0] level,
  input logic [THR_W-1:0] thr_empty,
  input logic [THR_W-1:0] thr_full,
  input logic             eor_present,
  input logic             strobe,
  input logic             strobe_eor,
  input logic             late_drop,
  input logic             req_n,
  input logic             req_status
);
  localparam bit DRAIN = (SIDE == SIDE_DRAIN);
  localparam int SW    = $clog2(LAT + 2);
  localparam int PADW  = CNT_W - THR_W;

  // Counts edges over which level and thresholds stayed unchanged.
  logic [CNT_W-1:0] lvl_q;
  logic [THR_W-1:0] te_q, tf_q;
  logic [SW-1:0]    same_cnt;
  logic             same_now, settled, quiet, eor_stb, in_band, lo, hi;

  assign same_now = (level == lvl_q) && (thr_empty == te_q) && (thr_full == tf_q);
  assign settled  = same_now && (same_cnt >= SW'(LAT));
  assign quiet    = !fifo_clear && !err_flag;
  assign eor_stb  = strobe && strobe_eor;
  assign lo       = (level <= {{PADW{1'b0}}, thr_empty});
  assign hi       = (level >= {{PADW{1'b0}}, thr_full});
  assign in_band  = !lo && !hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= '0;
      te_q     <= '0;
      tf_q     <= '0;
      same_cnt <= '0;
    end else begin
      lvl_q <= level;
      te_q  <= thr_empty;
      tf_q  <= thr_full;
      if (!same_now)                   same_cnt <= '0;
      else if (same_cnt <= SW'(LAT))   same_cnt <= same_cnt + 1'b1;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> req_n);

  p_err_r2: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !fifo_clear) |=> req_n);

  p_fill_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (!DRAIN && settled && quiet && lo) |=> !req_n);

  p_drain_full_r4: assert property (@(posedge clk) disable iff (rst)
    (DRAIN && settled && quiet && hi && !eor_stb) |=> (!req_n || (eor_stb && !late_drop)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (settled && quiet && in_band && (!DRAIN || (!eor_present && !eor_stb)))
      |=> ($stable(req_n) || (DRAIN && eor_stb && !late_drop)));

  p_eor_set_r7: assert property (@(posedge clk) disable iff (rst)
    (DRAIN && quiet && eor_present && !eor_stb) |=> (!req_n || (eor_stb && !late_drop)));

  p_early_r8: assert property (@(posedge clk) disable iff (rst)
    (DRAIN && eor_stb && !late_drop) |-> req_n);

  p_late_r9: assert property (@(posedge clk) disable iff (rst)
    (DRAIN && eor_stb && late_drop) |=> req_n);

  p_status_r10: assert property (@(posedge clk) disable iff (rst)
    req_status != req_n);
endmodule

bind fifo_req_gen fifo_req_gen_chk #(.DEPTH(DEPTH), .LAT(LAT), .SIDE(SIDE)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fifo_clear  (fifo_clear),
  .err_flag    (err_flag),
  .level       (level),
  .thr_empty   (thr_empty),
  .thr_full    (thr_full),
  .eor_present (eor_present),
  .strobe      (strobe),
  .strobe_eor  (strobe_eor),
  .late_drop   (late_drop),
  .req_n       (req_n),
  .req_status  (req_status)
);

// File: tb/fifo_req_gen_tb_top.sv
`timescale 1ns/1ps
module fifo_req_gen_tb_top;
  import fifo_req_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_clear = 1'b0, err_flag = 1'b0;
  logic [4:0] level = '0;
  logic [3:0] thr_empty = 4'd3, thr_full = 4'd4;
  logic       eor_present = 1'b0, strobe = 1'b0, strobe_eor = 1'b0, late_drop = 1'b0;
  logic       f_req_n, f_stat, d_req_n, d_stat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fifo_req_gen #(.DEPTH(16), .LAT(3), .SIDE(SIDE_FILL)) dut_i (
    .clk(clk), .rst(rst), .fifo_clear(fifo_clear), .err_flag(err_flag),
    .level(level), .thr_empty(thr_empty), .thr_full(thr_full),
    .eor_present(eor_present), .strobe(strobe), .strobe_eor(strobe_eor),
    .late_drop(late_drop), .req_n(f_req_n), .req_status(f_stat));

  fifo_req_gen #(.DEPTH(16), .LAT(3), .SIDE(SIDE_DRAIN)) dut_o (
    .clk(clk), .rst(rst), .fifo_clear(fifo_clear), .err_flag(err_flag),
    .level(level), .thr_empty(thr_empty), .thr_full(thr_full),
    .eor_present(eor_present), .strobe(strobe), .strobe_eor(strobe_eor),
    .late_drop(late_drop), .req_n(d_req_n), .req_status(d_stat));

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", what, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clear();
    fifo_clear = 1'b1;
    step(1);
    fifo_clear = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(2);
    chk(f_req_n, 1'b1, "R1 fill pin in reset");
    chk(d_req_n, 1'b1, "R1 drain pin in reset");
    chk(f_stat, 1'b0, "R10 fill status in reset");
    chk(d_stat, 1'b0, "R10 drain status in reset");
    rst = 1'b0;
  endtask

  task automatic t_fill_thresholds();
    thr_empty = 4'd3; thr_full = 4'd4; level = 5'd8;
    pulse_clear();
    step(3);
    level = 5'd2;
    step(2);
    chk(f_req_n, 1'b1, "R6 fill not yet active after two edges");
    step(1);
    chk(f_req_n, 1'b0, "R3 fill active at or below empty");
    chk(f_stat, 1'b1, "R10 fill status active");
    level = 5'd5; step(3);
    chk(f_req_n, 1'b1, "R3 fill inactive at or above full");
    level = 5'd16; step(3);
    chk(f_req_n, 1'b1, "R3 fill inactive at level 16");
    thr_empty = 4'd3; thr_full = 4'd10;
    level = 5'd2; step(3);
    level = 5'd6; step(4);
    chk(f_req_n, 1'b0, "R5 fill holds active in band");
    level = 5'd12; step(3);
    level = 5'd6; step(4);
    chk(f_req_n, 1'b1, "R5 fill holds inactive in band");
    thr_empty = 4'd8; thr_full = 4'd4; step(2);
    chk(f_req_n, 1'b0, "R3 fill empty rule wins when both hold");
  endtask

  task automatic t_fill_ignores_eor();
    thr_empty = 4'd3; thr_full = 4'd10; level = 5'd12; late_drop = 1'b0;
    step(4);
    eor_present = 1'b1; strobe = 1'b1; strobe_eor = 1'b1;
    #1 chk(f_req_n, 1'b1, "R11 fill ignores eor in cycle");
    step(2);
    chk(f_req_n, 1'b1, "R11 fill ignores eor_present");
    level = 5'd1; step(3);
    chk(f_req_n, 1'b0, "R11 fill active despite eor strobe");
    eor_present = 1'b0; strobe = 1'b0; strobe_eor = 1'b0;
  endtask

  task automatic t_clear_err();
    thr_empty = 4'd3; thr_full = 4'd4; level = 5'd0;
    step(4);
    chk(f_req_n, 1'b0, "R3 fill active at level 0");
    fifo_clear = 1'b1; step(1);
    chk(f_req_n, 1'b1, "R1 fill clear drops request");
    fifo_clear = 1'b0; step(1);
    chk(f_req_n, 1'b0, "R6 fill resumes one edge after clear");
    err_flag = 1'b1; step(1);
    chk(f_req_n, 1'b1, "R2 fill error drops request");
    step(3);
    chk(f_req_n, 1'b1, "R2 fill stays inactive under error");
    err_flag = 1'b0; step(1);
  endtask

  task automatic t_drain_thresholds();
    thr_empty = 4'd12; thr_full = 4'd13; level = 5'd0;
    pulse_clear();
    step(3);
    level = 5'd14;
    step(2);
    chk(d_req_n, 1'b1, "R6 drain not yet active after two edges");
    step(1);
    chk(d_req_n, 1'b0, "R4 drain active at or above full");
    level = 5'd12; step(3);
    chk(d_req_n, 1'b1, "R4 drain inactive at or below empty");
    thr_empty = 4'd4; thr_full = 4'd13;
    level = 5'd14; step(3);
    level = 5'd8; step(4);
    chk(d_req_n, 1'b0, "R5 drain holds active in band");
    level = 5'd3; step(3);
    chk(d_req_n, 1'b1, "R4 drain inactive after draining");
    thr_empty = 4'd10; thr_full = 4'd5; level = 5'd7; step(4);
    chk(d_req_n, 1'b0, "R4 drain full rule wins when both hold");
  endtask

  task automatic t_drain_eor();
    thr_empty = 4'd4; thr_full = 4'd13; level = 5'd0;
    pulse_clear();
    step(3);
    chk(d_req_n, 1'b1, "R4 drain idle when empty");
    eor_present = 1'b1; step(1);
    chk(d_req_n, 1'b0, "R7 drain active on end-of-record present");
    // early drop
    late_drop = 1'b0; strobe = 1'b1; strobe_eor = 1'b1;
    #1 chk(d_req_n, 1'b1, "R8 drain drops in strobe cycle");
    chk(d_stat, 1'b0, "R10 drain status follows early drop");
    step(1);
    strobe = 1'b0; strobe_eor = 1'b0; eor_present = 1'b0;
    #1 chk(d_req_n, 1'b1, "R8 drain stays inactive after early drop");
    eor_present = 1'b1; step(2);
    chk(d_req_n, 1'b0, "R7 drain active again");
    // late drop
    late_drop = 1'b1; strobe = 1'b1; strobe_eor = 1'b1;
    #1 chk(d_req_n, 1'b0, "R9 drain holds during strobe cycle");
    step(1);
    strobe = 1'b0; strobe_eor = 1'b0;
    #1 chk(d_req_n, 1'b1, "R9 drain low one clock despite eor_present");
    step(1);
    chk(d_req_n, 1'b0, "R9 drain reasserts after gap");
    err_flag = 1'b1; step(1);
    chk(d_req_n, 1'b1, "R2 drain error beats end-of-record");
    err_flag = 1'b0; fifo_clear = 1'b1; step(1);
    chk(d_req_n, 1'b1, "R1 drain clear beats end-of-record");
    fifo_clear = 1'b0; eor_present = 1'b0; late_drop = 1'b0;
    step(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    step(1);
    t_reset();
    t_fill_thresholds();
    t_fill_ignores_eor();
    t_clear_err();
    t_drain_thresholds();
    t_drain_eor();
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule